// File: doc/BRIEF.md
# Packed Unsigned Compare-Higher-or-Same Unit

This unit takes two packed operand vectors and compares them lane by lane as unsigned integers. Each result lane is all ones when the lane of the first operand is greater than or equal to the matching lane of the second operand. Otherwise the result lane is all zeros. A two-bit size code sets the lane width to 8, 16, 32 or 64 bits. A width bit sets the operated vector to 64 or 128 bits. A scalar flag reduces the operation to one 64-bit element. Encodings that are not allowed produce an undefined flag, so the surrounding pipeline can raise a trap.

Operations enter on a valid/ready input port and leave on a valid/ready output port through a single register stage. The result, the undefined flag and the output valid all come from that register. Every accepted operation therefore completes one cycle later, whatever the operand values are. The input is accepted only when the output register is empty or is being drained in the same cycle. While the output is stalled, the registered result stays fixed.

Top module: `simd_ucmp_unit`

## Requirements
- R1: The size code sets the lane width: code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane e occupies bits e*w through e*w+w-1 of each operand and of the result, counting from bit 0.
- R2: In vector mode, a width bit of 0 operates on bits 63:0 and a width bit of 1 operates on bits 127:0. The number of lanes is the operated width divided by the lane width.
- R3: Each operated lane of the result is all ones when opa's lane, read as unsigned, is greater than or equal to opb's lane, and all zeros otherwise. Equal lanes give all ones.
- R4: Whenever the operated width is 64 bits (scalar mode, or vector mode with width bit 0), result bits 127:64 are zero.
- R5: In vector mode, size code 3 with width bit 0 is reserved. It sets out_undef to 1 and forces the result to zero.
- R6: In scalar mode, one element at bits 63:0 is compared. Only size code 3 is legal. Size codes 0, 1 and 2 set out_undef to 1 and force the result to zero.
- R7: An operation accepted on a clock edge (in_valid and in_ready both high) shows on the outputs with out_valid high after exactly that edge. This holds for every operand value and for undefined encodings as well.
- R8: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid, out_result and out_undef hold their values.
- R9: While rst_n is low, out_valid, out_undef and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered on the input port |
| in_ready | output | 1 | The unit can accept an operation this cycle |
| in_opa | input | 128 | First operand, packed lanes |
| in_opb | input | 128 | Second operand, packed lanes |
| in_size | input | 2 | Lane size code (0:8, 1:16, 2:32, 3:64 bits) |
| in_wide | input | 1 | Vector width: 0 = 64 bits, 1 = 128 bits |
| in_scalar | input | 1 | Single 64-bit element mode |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_result | output | 128 | Lane mask result |
| out_undef | output | 1 | Encoding was undefined; result is zero |

## Verification
Several rules are checked on every cycle:
- the ready equation;
- the holding of the result during a stall;
- the fixed one-cycle completion after acceptance;
- the zero result that comes with an undefined flag;
- the flagging of the reserved vector case and the illegal scalar cases;
- the cleared upper half at 64-bit width;
- the rule that every lane of the result is uniformly all ones or all zeros.

Only the bench scenarios can show that each lane carries the correct comparison outcome, with the correct lane order and carry across bytes within wide lanes. They do this by checking equal operands, extreme values and seeded random vectors against a behavioural per-lane model.

// File: rtl/simd_ucmp_pkg.sv
package simd_ucmp_pkg;

  // Datapath geometry
  localparam int unsigned DATA_W   = 128;
  localparam int unsigned SEG_W    = 8;
  localparam int unsigned NSEG     = DATA_W / SEG_W;
  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned LEVELS   = 1 << SIZE_W;
  localparam int unsigned HALF_SEG = NSEG / 2;

  // Lane size codes
  typedef enum logic [SIZE_W-1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_size_e;

  // Decoded control for one operation
  typedef struct packed {
    logic               undef;
    logic [NSEG-1:0]    seg_active;
    lane_size_e         size;
  } op_ctrl_t;

endpackage

// File: rtl/simd_ucmp_decode.sv
module simd_ucmp_decode
  import simd_ucmp_pkg::*;
#(
  parameter int unsigned NUM_SEG = NSEG
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic              wide_i,
  input  logic              scalar_i,
  output logic              undef_o,
  output logic [NUM_SEG-1:0] seg_active_o,
  output lane_size_e        size_o
);

  localparam int unsigned LO_SEGS = NUM_SEG / 2;

  lane_size_e size_q;
  logic       full_width;
  logic       scalar_bad;
  logic       vector_bad;

  assign size_q = lane_size_e'(size_i);

  // Scalar forms accept only the 64-bit element
  assign scalar_bad = scalar_i && (size_q != LSZ_64);

  // Vector form: 64-bit lane on a 64-bit vector is reserved
  assign vector_bad = !scalar_i && (size_q == LSZ_64) && !wide_i;

  // Full 128-bit operation only for wide vectors
  assign full_width = !scalar_i && wide_i;

  always_comb begin
    for (int s = 0; s < int'(NUM_SEG); s++) begin
      if (s < int'(LO_SEGS)) begin
        seg_active_o[s] = 1'b1;
      end else begin
        seg_active_o[s] = full_width;
      end
    end
  end

  assign undef_o = scalar_bad || vector_bad;
  assign size_o  = size_q;

endmodule

// File: rtl/simd_ucmp_seg_tree.sv
module simd_ucmp_seg_tree
  import simd_ucmp_pkg::*;
#(
  parameter int unsigned WIDTH   = DATA_W,
  parameter int unsigned SEGW    = SEG_W,
  parameter int unsigned NLEVELS = LEVELS,
  localparam int unsigned NS     = WIDTH / SEGW
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [NS-1:0]    ge_lvl_o [NLEVELS]
);

  // gt/eq for the group of 2^k segments containing segment s
  logic [NS-1:0] gt_l [NLEVELS];
  logic [NS-1:0] eq_l [NLEVELS];

  genvar k, s;
  generate
    for (s = 0; s < NS; s++) begin : g_leaf
      logic [SEGW-1:0] sa;
      logic [SEGW-1:0] sb;
      assign sa = opa_i[s*SEGW +: SEGW];
      assign sb = opb_i[s*SEGW +: SEGW];
      assign gt_l[0][s] = (sa > sb);
      assign eq_l[0][s] = (sa == sb);
    end

    for (k = 1; k < NLEVELS; k++) begin : g_level
      localparam int unsigned HALF = 1 << (k - 1);
      for (s = 0; s < NS; s++) begin : g_seg
        localparam int unsigned BASE = (s >> k) << k;
        localparam int unsigned HI   = BASE + HALF;
        localparam int unsigned LO   = BASE;
        // Upper half decides unless it is equal
        assign gt_l[k][s] = gt_l[k-1][HI] | (eq_l[k-1][HI] & gt_l[k-1][LO]);
        assign eq_l[k][s] = eq_l[k-1][HI] & eq_l[k-1][LO];
      end
    end

    for (k = 0; k < NLEVELS; k++) begin : g_ge
      assign ge_lvl_o[k] = gt_l[k] | eq_l[k];
    end
  endgenerate

endmodule

// File: rtl/simd_ucmp_mask_expand.sv
module simd_ucmp_mask_expand
  import simd_ucmp_pkg::*;
#(
  parameter int unsigned WIDTH   = DATA_W,
  parameter int unsigned SEGW    = SEG_W,
  parameter int unsigned NLEVELS = LEVELS,
  localparam int unsigned NS     = WIDTH / SEGW
) (
  input  logic [NS-1:0]    ge_lvl_i [NLEVELS],
  input  op_ctrl_t         ctrl_i,
  output logic [WIDTH-1:0] result_o
);

  logic [NS-1:0] ge_sel;
  logic [NS-1:0] seg_on;

  always_comb begin
    ge_sel = '0;
    for (int k = 0; k < int'(NLEVELS); k++) begin
      if (int'(ctrl_i.size) == k) begin
        ge_sel = ge_lvl_i[k];
      end
    end
  end

  assign seg_on = ge_sel & ctrl_i.seg_active & {NS{!ctrl_i.undef}};

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_fill
      assign result_o[s*SEGW +: SEGW] = {SEGW{seg_on[s]}};
    end
  endgenerate

endmodule

// File: rtl/simd_ucmp_out_stage.sv
module simd_ucmp_out_stage #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid_i,
  output logic             up_ready_o,
  input  logic [WIDTH-1:0] up_result_i,
  input  logic             up_undef_i,
  output logic             dn_valid_o,
  input  logic             dn_ready_i,
  output logic [WIDTH-1:0] dn_result_o,
  output logic             dn_undef_o
);

  logic load;

  assign up_ready_o = !dn_valid_o || dn_ready_i;
  assign load       = up_valid_i && up_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid_o  <= 1'b0;
      dn_result_o <= '0;
      dn_undef_o  <= 1'b0;
    end else if (load) begin
      dn_valid_o  <= 1'b1;
      dn_result_o <= up_result_i;
      dn_undef_o  <= up_undef_i;
    end else if (dn_ready_i) begin
      dn_valid_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_ucmp_unit.sv
module simd_ucmp_unit
  import simd_ucmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_wide,
  input  logic              in_scalar,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_undef
);

  op_ctrl_t          ctrl;
  logic [NSEG-1:0]   ge_lvl [LEVELS];
  logic [DATA_W-1:0] mask_comb;

  simd_ucmp_decode #(
    .NUM_SEG (NSEG)
  ) decode_i (
    .size_i       (in_size),
    .wide_i       (in_wide),
    .scalar_i     (in_scalar),
    .undef_o      (ctrl.undef),
    .seg_active_o (ctrl.seg_active),
    .size_o       (ctrl.size)
  );

  simd_ucmp_seg_tree #(
    .WIDTH   (DATA_W),
    .SEGW    (SEG_W),
    .NLEVELS (LEVELS)
  ) tree_i (
    .opa_i    (in_opa),
    .opb_i    (in_opb),
    .ge_lvl_o (ge_lvl)
  );

  simd_ucmp_mask_expand #(
    .WIDTH   (DATA_W),
    .SEGW    (SEG_W),
    .NLEVELS (LEVELS)
  ) expand_i (
    .ge_lvl_i (ge_lvl),
    .ctrl_i   (ctrl),
    .result_o (mask_comb)
  );

  simd_ucmp_out_stage #(
    .WIDTH (DATA_W)
  ) stage_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_valid_i  (in_valid),
    .up_ready_o  (in_ready),
    .up_result_i (mask_comb),
    .up_undef_i  (ctrl.undef),
    .dn_valid_o  (out_valid),
    .dn_ready_i  (out_ready),
    .dn_result_o (out_result),
    .dn_undef_o  (out_undef)
  );

endmodule

// File: rtl/simd_ucmp_checker.sv
module simd_ucmp_checker
  import simd_ucmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_opa,
  input logic [DATA_W-1:0] in_opb,
  input logic [SIZE_W-1:0] in_size,
  input logic              in_wide,
  input logic              in_scalar,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_undef
);

  logic accept;
  assign accept = in_valid && in_ready;

  // Every lane of the given size is uniformly all ones or all zeros
  function automatic logic lanes_uniform(input logic [DATA_W-1:0] r,
                                         input logic [SIZE_W-1:0] sz);
    int unsigned w;
    logic ok;
    w  = SEG_W << sz;
    ok = 1'b1;
    for (int unsigned e = 0; e < DATA_W / SEG_W; e++) begin
      if (e < DATA_W / w) begin
        for (int unsigned b = 0; b < w; b++) begin
          if (r[e*w + b] != r[e*w]) ok = 1'b0;
        end
      end
    end
    return ok;
  endfunction

  // R8: ready equation
  p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R8: stalled output holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_undef)));

  // R7: fixed one-cycle completion
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R5/R6: undefined result is zero
  p_undef_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |-> (out_result == '0));

  // R5: reserved vector case flagged
  p_reserved_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_scalar && in_size == 2'd3 && !in_wide) |=> out_undef);

  // R6: illegal scalar sizes flagged
  p_scalar_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_scalar && in_size != 2'd3) |=> out_undef);

  // R6: legal scalar not flagged
  p_scalar_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_scalar && in_size == 2'd3) |=> !out_undef);

  // R4: upper half cleared at 64-bit width
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_scalar || !in_wide)) |=> (out_result[DATA_W-1:DATA_W/2] == '0));

  // R3: lanes uniformly filled
  p_lane_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> lanes_uniform(out_result, $past(in_size)));

  // R9: reset clears outputs
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_clear_r9: assert (!out_valid && !out_undef && out_result == '0);
    end
  end

endmodule

bind simd_ucmp_unit simd_ucmp_checker chk_i (.*);

// File: tb/simd_ucmp_unit_tb_top.sv
module simd_ucmp_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_opa = '0;
  logic [127:0] in_opb = '0;
  logic [1:0]   in_size = '0;
  logic         in_wide = 1'b0;
  logic         in_scalar = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic         out_undef;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  simd_ucmp_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_opa     (in_opa),
    .in_opb     (in_opb),
    .in_size    (in_size),
    .in_wide    (in_wide),
    .in_scalar  (in_scalar),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_undef  (out_undef)
  );

  // Behavioural model: {undef, result}
  function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz, input logic wide,
                                         input logic scalar);
    int unsigned w, opw, n;
    logic undef;
    logic [127:0] r, ones;
    logic [63:0] ea, eb;
    w     = 8 << sz;
    opw   = (!scalar && wide) ? 128 : 64;
    undef = scalar ? (sz != 2'd3) : (sz == 2'd3 && !wide);
    r     = '0;
    if (!undef) begin
      n    = scalar ? 1 : opw / w;
      ones = (w == 64) ? 128'hFFFF_FFFF_FFFF_FFFF : ((128'd1 << w) - 128'd1);
      for (int unsigned e = 0; e < n; e++) begin
        ea = 64'((a >> (e*w)) & ones);
        eb = 64'((b >> (e*w)) & ones);
        if (ea >= eb) r = r | (ones << (e*w));
      end
    end
    return {undef, r};
  endfunction

  task automatic check(input string tag, input logic [128:0] act, input logic [128:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [127:0] a, input logic [127:0] b,
                         input logic [1:0] sz, input logic wide, input logic scalar,
                         input string tag);
    @(negedge clk);
    check("R7 idle before issue", 129'(out_valid), 129'd0);
    in_opa = a; in_opb = b; in_size = sz; in_wide = wide; in_scalar = scalar;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid after one edge", 129'(out_valid), 129'd1);
    check(tag, {out_undef, out_result}, model(a, b, sz, wide, scalar));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, hold_exp;
    void'($urandom(32'h5EED_0042));

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {out_undef, out_result}, 129'd0);
    check("R9 reset valid", 129'(out_valid), 129'd0);
    rst_n = 1'b1;

    // Directed: every size/width/mode combination with extremes and equality
    for (int sc = 0; sc < 2; sc++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int sz = 0; sz < 4; sz++) begin
          run_one('1, '0, 2'(sz), 1'(wd), 1'(sc), "R1/R2/R3/R4/R5/R6 ones vs zero");
          run_one('0, '1, 2'(sz), 1'(wd), 1'(sc), "R3 zero vs ones");
          a = rnd128();
          run_one(a, a, 2'(sz), 1'(wd), 1'(sc), "R3 equal operands");
        end
      end
    end

    // R5: reserved vector arrangement
    run_one('1, '0, 2'd3, 1'b0, 1'b0, "R5 reserved vector");
    check("R5 undef flag", 129'(out_undef), 129'd1);
    // R6: scalar with byte size is undefined
    run_one('1, '0, 2'd0, 1'b1, 1'b1, "R6 scalar bad size");
    check("R6 undef flag", 129'(out_undef), 129'd1);
    // R4: upper half ignored at 64-bit width
    run_one({64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, '0, 2'd0, 1'b0, 1'b0, "R4 upper half zero");
    // R1: lane order, alternating greater/lesser 16-bit lanes
    run_one(128'h0001_0000_0001_0000_0001_0000_0001_0000,
            128'h0000_0001_0000_0001_0000_0001_0000_0001, 2'd1, 1'b1, 1'b0, "R1 lane order");
    // R3: carry between bytes inside a 32-bit lane
    run_one(128'h0000_0100, 128'h0000_00FF, 2'd2, 1'b0, 1'b0, "R3 wide-lane carry");

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    a = rnd128(); b = rnd128();
    in_opa = a; in_opb = b; in_size = 2'd2; in_wide = 1'b1; in_scalar = 1'b0;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hold_exp = model(a, b, 2'd2, 1'b1, 1'b0)[127:0];
    check("R8 ready low when stalled", 129'(in_ready), 129'd0);
    in_opa = ~a; in_opb = a;
    @(posedge clk);
    @(negedge clk);
    check("R8 result held", 129'(out_result), 129'(hold_exp));
    check("R8 valid held", 129'(out_valid), 129'd1);
    out_ready = 1'b1;
    #0;
    check("R8 ready with drain", 129'(in_ready), 129'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next result", {out_undef, out_result}, model(~a, a, 2'd2, 1'b1, 1'b0));
    @(negedge clk);

    // Random vectors with near-equal bias
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      logic wd, sc;
      a  = rnd128();
      case ($urandom % 4)
        0: b = a;
        1: b = a ^ (128'h1 << ($urandom % 128));
        2: b = a & rnd128();
        default: b = rnd128();
      endcase
      sz = 2'($urandom);
      wd = 1'($urandom);
      sc = (($urandom % 4) == 0);
      run_one(a, b, sz, wd, sc, "R1/R2/R3 random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule